// File: doc/BRIEF.md
# 8-bit Compare Timer with CTC and Fast PWM

An 8-bit timer/counter with a single compare channel. It is clocked by the system clock and advances once per timer tick. Ticks come from a free-running prescaler that supplies one of seven fixed divide ratios. Software uses a small write port to program three things: a control byte (waveform mode, output action and prescaler ratio), a compare byte, and a write-one-to-clear flag register. The block drives one waveform output. An output-enable input gates that output, standing in for the direction setting of a pin.

In clear-on-compare mode the counter restarts after it reaches the compare value. The output can toggle, clear or set on each match, which gives a square wave whose period is set by the compare value. In fast PWM mode the counter sweeps 0 to 255 in a single slope. The output is set or cleared at the bottom of the sweep and takes the opposite level at the compare match. In this mode the compare value is double-buffered and is loaded at the wrap. Two sticky flags record overflow and compare events for polling software.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the waveform output, the overflow flag and the compare flag are all 0.
- R2: Control bits [6:4] select the tick rate. Codes 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. Code 0 stops the counter.
- R3: With mode code 2 in control bits [1:0] (clear-on-compare) and output action code 1 in bits [3:2], the output toggles on every match. Matches are N·(1+C) clocks apart, where N is the prescaler ratio and C is the compare value written at address 1.
- R4: In clear-on-compare mode, output action code 2 drives the output to 0 at a match and code 3 drives it to 1.
- R5: With mode code 3 (fast PWM) and action code 2, the output is 1 for N·(C+1) clocks of every 256·N-clock period.
- R6: With mode code 3 and action code 3 (inverted), the output is 1 for N·(255−C) clocks of every 256·N-clock period.
- R7: The overflow flag (bit 0) is set on the tick where the counter goes from 255 to 0. In fast PWM mode this happens every 256 ticks.
- R8: The overflow flag (bit 0) and the compare flag (bit 1) stay set until a write to address 2 with that bit at 1. A write with the bit at 0 leaves the flag unchanged.
- R9: In fast PWM mode a new compare value takes effect only at the next wrap from 255 to 0. In clear-on-compare mode it takes effect on the following clock.
- R10: The output is 0 while output-enable is 0, and the internal waveform keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 compare, 2 flag clear |
| wr_data | input | 8 | Write data |
| out_en | input | 1 | Output gate (pin drive enable) |
| wave_out | output | 1 | Gated waveform output |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The embedded assertions watch several rules on every clock: the counter wraps with the overflow flag, the counter holds still when the prescaler is stopped, the active compare value stays put between wraps in PWM mode, flags clear on a write-one, and the output sets or clears at the bottom or toggles on a match. Frequencies and duty cycles are measured only by the bench's sweeps. These cover several compare values and all prescaler codes, both PWM polarities, and the buffered compare write seen from the output pin. The bench also checks output gating with the waveform still alive underneath.

// File: rtl/pwm_timer8.sv
module pwm_timer8 #(
  parameter int CW = 8,
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          out_en,
  output logic          wave_out,
  output logic          ovf_flag,
  output logic          cmp_flag
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};
  localparam logic [1:0] M_CTC = 2'd2;
  localparam logic [1:0] M_PWM = 2'd3;

  logic [1:0]    mode_q, act_q;
  logic [2:0]    psel_q;
  logic [CW-1:0] cnt_q, cmp_buf_q, cmp_act_q;
  logic [PW-1:0] pre_q;
  logic          wave_q, ovf_q, cmpf_q;
  logic          tick, run, hit, wrap, clr;

  always_comb begin
    unique case (psel_q)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[4:0];
      3'd4:    tick = &pre_q[5:0];
      3'd5:    tick = &pre_q[6:0];
      3'd6:    tick = &pre_q[7:0];
      3'd7:    tick = &pre_q[PW-1:0];
      default: tick = 1'b0;
    endcase
  end

  assign run  = tick && (mode_q == M_CTC || mode_q == M_PWM);
  assign hit  = run && (cnt_q == cmp_act_q);
  assign wrap = run && (cnt_q == TOP);
  assign clr  = wr_en && (wr_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      act_q     <= '0;
      psel_q    <= '0;
      cmp_buf_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == 2'd0) begin
        mode_q <= wr_data[1:0];
        act_q  <= wr_data[3:2];
        psel_q <= wr_data[6:4];
      end
      if (wr_addr == 2'd1) cmp_buf_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_act_q <= '0;
    else if (mode_q != M_PWM || wrap) cmp_act_q <= cmp_buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (run) begin
      if (mode_q == M_CTC && hit) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else if (mode_q == M_CTC && hit) begin
      unique case (act_q)
        2'd1:    wave_q <= ~wave_q;
        2'd2:    wave_q <= 1'b0;
        2'd3:    wave_q <= 1'b1;
        default: wave_q <= wave_q;
      endcase
    end else if (mode_q == M_PWM && act_q[1]) begin
      if (wrap)     wave_q <= ~act_q[0];
      else if (hit) wave_q <= act_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ovf_q  <= wrap | (ovf_q  & ~(clr & wr_data[0]));
      cmpf_q <= hit  | (cmpf_q & ~(clr & wr_data[1]));
    end
  end

  assign wave_out = out_en & wave_q;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmpf_q;

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (psel_q == 3'd0) |=> (cnt_q == $past(cnt_q)));

  p_ctc_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_CTC && act_q == 2'd1 && hit) |=> (wave_q != $past(wave_q)));

  p_pwm_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM && act_q == 2'd2 && wrap) |=> wave_q);

  p_pwm_bottom_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM && act_q == 2'd3 && wrap) |=> !wave_q);

  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == '0 && ovf_q));

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && wr_data[0] && !wrap) |=> !ovf_q);

  p_buf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_PWM && !wrap) |=> (cmp_act_q == $past(cmp_act_q)));
endmodule

// File: tb/pwm_timer8_tb.sv
module pwm_timer8_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       out_en = 1'b1;
  logic       wave_out, ovf_flag, cmp_flag;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  pwm_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_en(out_en), .wave_out(wave_out),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input int ps, input int act, input int md);
    return {1'b0, 3'(ps), 2'(act), 2'(md)};
  endfunction

  task automatic wait_edge(input int cap, output bit seen);
    logic prev;
    int g;
    prev = wave_out; g = 0; seen = 1'b0;
    while (g < cap) begin
      @(negedge clk); g++;
      if (wave_out != prev) begin seen = 1'b1; break; end
    end
  endtask

  task automatic half_period(output int h);
    bit s;
    int t0;
    wait_edge(10000, s);
    wait_edge(10000, s);
    t0 = cyc;
    wait_edge(10000, s);
    h = s ? cyc - t0 : -1;
  endtask

  task automatic count_high(input int len, output int hi);
    hi = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (wave_out) hi++;
    end
  endtask

  task automatic wait_ovf(output int t);
    int g;
    g = 0;
    while (!ovf_flag && g < 5000) begin @(negedge clk); g++; end
    t = cyc;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int h, hi, t0, t1, ratio;
    bit s;
    repeat (3) @(negedge clk);
    check(wave_out == 0 && ovf_flag == 0 && cmp_flag == 0, "R1 in reset", wave_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(wave_out == 0 && ovf_flag == 0 && cmp_flag == 0, "R1 after reset", ovf_flag, 0);

    // R3: toggle period in CTC at ratio 1, then R2 prescaler sweep
    wr(2'd1, 8'd1);
    wr(2'd0, ctl(1, 1, 2));
    for (int p = 1; p <= 7; p++) begin
      ratio = (p == 1) ? 1 : (p == 2) ? 8 : (p == 3) ? 32 : (p == 4) ? 64 :
              (p == 5) ? 128 : (p == 6) ? 256 : 1024;
      wr(2'd0, ctl(p, 1, 2));
      half_period(h);
      check(h == 2 * ratio, $sformatf("R2 prescale code %0d", p), h, 2 * ratio);
    end
    wr(2'd0, ctl(0, 1, 2));
    wait_edge(3000, s);
    check(!s, "R2 code 0 stops", s, 0);

    for (int c = 0; c <= 20; c++) begin
      wr(2'd1, 8'(c));
      wr(2'd0, ctl(1, 1, 2));
      half_period(h);
      check(h == c + 1, $sformatf("R3 ctc cmp %0d", c), h, c + 1);
    end

    // R4 set/clear on match
    wr(2'd1, 8'd3);
    wr(2'd0, ctl(1, 2, 2));
    repeat (300) @(negedge clk);
    check(wave_out == 0, "R4 clear on match", wave_out, 0);
    wr(2'd0, ctl(1, 3, 2));
    repeat (20) @(negedge clk);
    check(wave_out == 1, "R4 set on match", wave_out, 1);
    wr(2'd0, ctl(1, 2, 2));
    repeat (20) @(negedge clk);
    check(wave_out == 0, "R4 clear again", wave_out, 0);

    // R5 / R6 duty sweeps
    for (int c = 0; c <= 255; c += 17) begin
      wr(2'd1, 8'(c));
      wr(2'd0, ctl(1, 2, 3));
      repeat (520) @(negedge clk);
      count_high(256, hi);
      check(hi == c + 1, $sformatf("R5 duty cmp %0d", c), hi, c + 1);
    end
    for (int c = 0; c <= 255; c += 17) begin
      wr(2'd1, 8'(c));
      wr(2'd0, ctl(1, 3, 3));
      repeat (520) @(negedge clk);
      count_high(256, hi);
      check(hi == 255 - c, $sformatf("R6 duty cmp %0d", c), hi, 255 - c);
    end
    wr(2'd1, 8'h40);
    wr(2'd0, ctl(2, 2, 3));
    repeat (4200) @(negedge clk);
    count_high(2048, hi);
    check(hi == 8 * 65, "R5 duty at ratio 8", hi, 520);

    // R7 overflow spacing
    wr(2'd0, ctl(1, 2, 3));
    wr(2'd2, 8'h03);
    wait_ovf(t0);
    wr(2'd2, 8'h01);
    wait_ovf(t1);
    check(t1 - t0 == 256, "R7 overflow period", t1 - t0, 256);

    // R9 buffered compare
    wr(2'd1, 8'h80);
    repeat (600) @(negedge clk);
    wr(2'd2, 8'h01);
    wait_ovf(t0);
    wr(2'd1, 8'h10);
    repeat (40) @(negedge clk);
    check(wave_out == 1, "R9 old compare kept", wave_out, 1);
    wr(2'd2, 8'h01);
    wait_ovf(t0);
    repeat (3) @(negedge clk);
    count_high(256, hi);
    check(hi == 17, "R9 new compare after wrap", hi, 17);

    // R10 gate
    out_en = 1'b0;
    count_high(256, hi);
    check(hi == 0, "R10 gated low", hi, 0);
    out_en = 1'b1;
    count_high(256, hi);
    check(hi == 17, "R10 waveform kept running", hi, 17);

    // R8 sticky flags, selective clear (counter stopped)
    repeat (300) @(negedge clk);
    wr(2'd0, ctl(0, 2, 3));
    check(ovf_flag && cmp_flag, "R8 both set", {ovf_flag, cmp_flag}, 3);
    wr(2'd2, 8'h00);
    check(ovf_flag && cmp_flag, "R8 zero write keeps", {ovf_flag, cmp_flag}, 3);
    wr(2'd2, 8'h01);
    check(!ovf_flag && cmp_flag, "R8 clear ovf only", {ovf_flag, cmp_flag}, 1);
    wr(2'd2, 8'h02);
    check(!ovf_flag && !cmp_flag, "R8 clear cmp", {ovf_flag, cmp_flag}, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule